// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Controller

This block watches the address strobe of a microcontroller bus and counts input-clock periods in which the strobe does not change. Once software has enabled the unit and the strobe has been still for a programmable number of periods, the block enters a power-down state. In that state it asserts a standby request to every memory and isolates the microcontroller address/data bus from internal memories and logic. It also applies a class-dependent treatment to each output port. The programmable logic and the ports themselves stay active.

Three events return the block to normal operation: a change of level on the address strobe, a falling edge on the active-low chip-select input, or the reset input going high. A small write-only register set enables the unit. It also selects which microcontroller control lines, and whether the common logic clock, are held off the logic arrays while power-down lasts. The idle counter always runs on the raw input clock, so blocking the logic clock never stops the idle count.

Top module: `apd_ctrl`

## Requirements
- R1: While reset is high and after it falls, pd_flag, bus_iso and every mem_stby bit are 0. The enable bit, the clock-block bit and the control mask are all 0.
- R2: With the unit enabled, pd_flag rises at the IDLE_CYCLES-th rising clock edge after the edge that first samples a strobe change, provided the strobe is unchanged at each of those edges. With the default of 15, a toggle driven between edges gives pd_flag = 0 after 15 edges and 1 after 16.
- R3: The idle counter saturates at IDLE_CYCLES and never wraps. After a long idle period with the unit disabled, setting the enable bit gives pd_flag = 1 one edge after the write edge.
- R4: In power-down, a rising or a falling change on as_strobe clears pd_flag at the next clock edge and restarts the idle count.
- R5: In power-down, a high-to-low change of csi_n clears pd_flag at the next edge and restarts the idle count. A rising csi_n has no effect. A csi_n held low does not stop re-entry after a full idle interval.
- R6: Reset high clears pd_flag at once, without waiting for a clock, and keeps it clear for as long as it stays high.
- R7: With the enable bit 0, pd_flag never rises. Clearing the enable bit while in power-down clears pd_flag one edge after the write edge.
- R8: In power-down, every mem_stby bit is 1, bus_iso is 1 and int_ad is all zeros. In normal operation, mem_stby is 0, bus_iso is 0 and int_ad equals mcu_ad.
- R9: Port classes are set per port by PORT_CLASS as 3-bit codes: 0 general I/O, 1 logic output, 2 address out, 3 data, 4 peripheral. The default is ports 0 to 4 in that order. In power-down, classes 0 to 2 pass port_oe_req and assert port_hold, while classes 3 and 4 drive port_oe = 0 and port_hold = 0. In normal operation, port_oe equals port_oe_req and port_hold is 0.
- R10: Register writes take effect at the write edge. cfg_sel = 0 selects bit 0 as enable and bit 1 as clock block. cfg_sel = 1 selects bits N_CTL-1:0 as the control block mask. In power-down, logic_ctl[i] is 0 where the mask bit is 1 and follows mcu_ctl[i] elsewhere, and logic_clk_en is the inverse of the clock-block bit. In normal operation, logic_ctl equals mcu_ctl and logic_clk_en is 1. Power-down entry still occurs with the clock blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Free-running input clock for the idle counter |
| rst | input | 1 | Active-high asynchronous reset, also a wake source |
| as_strobe | input | 1 | Microcontroller address strobe; any level change is activity |
| csi_n | input | 1 | Active-low chip-select input; a falling edge wakes |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 control-line block mask |
| cfg_wdata | input | CFG_W | Register write data |
| mcu_ad | input | AD_W | Microcontroller address/data bus |
| mcu_ctl | input | N_CTL | Microcontroller control lines toward the logic arrays |
| port_oe_req | input | N_PORT | Output enables requested by the port logic |
| pd_flag | output | 1 | High while in power-down |
| mem_stby | output | N_MEM | Standby request, one per memory |
| bus_iso | output | 1 | High while the bus is isolated from the internals |
| int_ad | output | AD_W | Gated address/data bus toward memories and logic |
| logic_ctl | output | N_CTL | Gated control lines toward the logic arrays |
| logic_clk_en | output | 1 | Enable for the common clock into the logic arrays |
| port_oe | output | N_PORT | Output enable applied to each port |
| port_hold | output | N_PORT | Hold-last-level control for each port |

## Verification
The power-down state is a register, and every output follows it through combinational logic. Entry is therefore due exactly IDLE_CYCLES + 1 edges after a strobe toggle is driven between edges. Wake by strobe or chip-select is due one edge after the stimulus, and a register write shows its effect on the edge after the write edge. Reset acts without a clock. The bench drives and samples 2 ns after each rising edge, and checks the state both one edge before and at each due edge. This proves that entry is neither early nor late. Gated outputs are checked in the same sampling slot as the input change that feeds them.

// File: rtl/apd_pkg.sv
package apd_pkg;
   // Port treatment classes; the numeric codes are used in PORT_CLASS.
   typedef enum logic [2:0] {
      PC_GPIO      = 3'd0,
      PC_LOGIC_OUT = 3'd1,
      PC_ADDR_OUT  = 3'd2,
      PC_DATA      = 3'd3,
      PC_PERIPH    = 3'd4
   } port_class_e;

   localparam int PC_W = 3;

   // Classes that keep their level in power-down (hold) rather than float.
   function automatic logic class_holds(input logic [PC_W-1:0] cls);
      return (cls == PC_GPIO) || (cls == PC_LOGIC_OUT) || (cls == PC_ADDR_OUT);
   endfunction

   function automatic logic class_valid(input logic [PC_W-1:0] cls);
      return cls <= PC_PERIPH;
   endfunction
endpackage

// File: rtl/apd_cfg_regs.sv
module apd_cfg_regs #(
   parameter int N_CTL = 4,
   parameter int CFG_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic             sel,
   input  logic [CFG_W-1:0] wdata,
   output logic             en,
   output logic             clk_blk,
   output logic [N_CTL-1:0] ctl_mask
);
   if (CFG_W < 2 || CFG_W < N_CTL) begin : g_bad_w
      $error("apd_cfg_regs: CFG_W too narrow");
   end

   logic             en_q, clk_blk_q;
   logic [N_CTL-1:0] mask_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         en_q      <= 1'b0;
         clk_blk_q <= 1'b0;
         mask_q    <= '0;
      end else if (we) begin
         if (!sel) begin
            en_q      <= wdata[0];
            clk_blk_q <= wdata[1];
         end else begin
            mask_q    <= wdata[N_CTL-1:0];
         end
      end
   end

   assign en       = en_q;
   assign clk_blk  = clk_blk_q;
   assign ctl_mask = mask_q;
endmodule

// File: rtl/apd_idle_timer.sv
module apd_idle_timer #(
   parameter int IDLE_CYCLES = 15,
   parameter int CNT_W       = $clog2(IDLE_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe,
   input  logic csi_n,
   output logic as_edge,
   output logic csi_fall,
   output logic idle_done
);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(IDLE_CYCLES);
   localparam logic [CNT_W-1:0] CNT_TRIG = CNT_W'(IDLE_CYCLES - 1);

   if (IDLE_CYCLES < 2) begin : g_bad_idle
      $error("apd_idle_timer: IDLE_CYCLES must be at least 2");
   end
   if (CNT_W < $clog2(IDLE_CYCLES + 1)) begin : g_bad_cw
      $error("apd_idle_timer: CNT_W cannot hold IDLE_CYCLES");
   end

   logic             as_d, csi_d;
   logic [CNT_W-1:0] cnt_q;

   assign as_edge  = strobe ^ as_d;
   assign csi_fall = csi_d & ~csi_n;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         as_d  <= 1'b0;
         csi_d <= 1'b1;
      end else begin
         as_d  <= strobe;
         csi_d <= csi_n;
      end
   end

   // Restart on any wake event, otherwise count up and stop at the limit.
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (as_edge || csi_fall) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // Threshold is met when the current edge completes the idle interval.
   assign idle_done = (cnt_q >= CNT_TRIG);

   AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_MAX) else $error("idle counter beyond limit"); // R3
   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == CNT_MAX && !as_edge && !csi_fall) |=> cnt_q == CNT_MAX)
      else $error("idle counter left saturation without wake"); // R3
endmodule

// File: rtl/apd_pd_state.sv
module apd_pd_state (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic idle_done,
   input  logic as_edge,
   input  logic csi_fall,
   output logic pd
);
   typedef enum logic {ST_RUN = 1'b0, ST_DOWN = 1'b1} pd_state_e;

   pd_state_e st_q, st_d;
   logic      wake;

   assign wake = as_edge | csi_fall;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN:  if (en && idle_done && !wake) st_d = ST_DOWN;
         ST_DOWN: if (!en || wake)              st_d = ST_RUN;
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) st_q <= ST_RUN;
      else     st_q <= st_d;
   end

   assign pd = (st_q == ST_DOWN);

   AST_WAKE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
      as_edge |=> !pd) else $error("strobe change did not wake"); // R4
   AST_WAKE_ON_CSI: assert property (@(posedge clk) disable iff (rst)
      csi_fall |=> !pd) else $error("chip-select fall did not wake"); // R5
   AST_NO_ENTRY_DISABLED: assert property (@(posedge clk) disable iff (rst)
      !en |=> !pd) else $error("power-down while disabled"); // R7
   AST_ENTRY_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
      $rose(pd) |-> $past(idle_done) && $past(en))
      else $error("power-down entered early"); // R2
endmodule

// File: rtl/apd_port_ctl.sv
module apd_port_ctl
   import apd_pkg::*;
#(
   parameter logic [PC_W-1:0] CLS = PC_GPIO
) (
   input  logic pd,
   input  logic oe_req,
   output logic oe,
   output logic hold
);
   if (!class_valid(CLS)) begin : g_bad_cls
      $error("apd_port_ctl: unknown port class");
   end

   if (class_holds(CLS)) begin : g_hold
      // Level kept: driver stays on, output latched at its last value.
      assign oe   = oe_req;
      assign hold = pd;
   end else begin : g_float
      // Data and peripheral ports release the pins.
      assign oe   = oe_req & ~pd;
      assign hold = 1'b0;
   end
endmodule

// File: rtl/apd_ctrl.sv
module apd_ctrl
   import apd_pkg::*;
#(
   parameter int IDLE_CYCLES = 15,
   parameter int AD_W        = 8,
   parameter int N_CTL       = 4,
   parameter int N_MEM       = 3,
   parameter int N_PORT      = 5,
   parameter logic [PC_W*N_PORT-1:0] PORT_CLASS =
      {PC_PERIPH, PC_DATA, PC_ADDR_OUT, PC_LOGIC_OUT, PC_GPIO},
   localparam int CFG_W = (N_CTL > 2) ? N_CTL : 2
) (
   input  logic              clk_in,
   input  logic              rst,
   input  logic              as_strobe,
   input  logic              csi_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic [AD_W-1:0]   mcu_ad,
   input  logic [N_CTL-1:0]  mcu_ctl,
   input  logic [N_PORT-1:0] port_oe_req,
   output logic              pd_flag,
   output logic [N_MEM-1:0]  mem_stby,
   output logic              bus_iso,
   output logic [AD_W-1:0]   int_ad,
   output logic [N_CTL-1:0]  logic_ctl,
   output logic              logic_clk_en,
   output logic [N_PORT-1:0] port_oe,
   output logic [N_PORT-1:0] port_hold
);
   localparam int CNT_W = $clog2(IDLE_CYCLES + 1);

   if (AD_W < 1 || N_CTL < 1 || N_MEM < 1 || N_PORT < 1) begin : g_bad_dim
      $error("apd_ctrl: every width and count must be positive");
   end

   logic             en, clk_blk, pd;
   logic [N_CTL-1:0] ctl_mask;
   logic             as_edge, csi_fall, idle_done;

   apd_cfg_regs #(.N_CTL(N_CTL), .CFG_W(CFG_W)) i_cfg (
      .clk      (clk_in),
      .rst      (rst),
      .we       (cfg_we),
      .sel      (cfg_sel),
      .wdata    (cfg_wdata),
      .en       (en),
      .clk_blk  (clk_blk),
      .ctl_mask (ctl_mask)
   );

   // Runs on the raw input clock: the logic-array clock block never reaches it.
   apd_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES), .CNT_W(CNT_W)) i_timer (
      .clk       (clk_in),
      .rst       (rst),
      .strobe    (as_strobe),
      .csi_n     (csi_n),
      .as_edge   (as_edge),
      .csi_fall  (csi_fall),
      .idle_done (idle_done)
   );

   apd_pd_state i_state (
      .clk       (clk_in),
      .rst       (rst),
      .en        (en),
      .idle_done (idle_done),
      .as_edge   (as_edge),
      .csi_fall  (csi_fall),
      .pd        (pd)
   );

   assign pd_flag      = pd;
   assign bus_iso      = pd;
   assign int_ad       = pd ? '0 : mcu_ad;
   assign logic_clk_en = ~(pd & clk_blk);

   for (genvar m = 0; m < N_MEM; m++) begin : g_mem
      assign mem_stby[m] = pd;
   end

   for (genvar c = 0; c < N_CTL; c++) begin : g_ctl
      assign logic_ctl[c] = mcu_ctl[c] & ~(pd & ctl_mask[c]);
   end

   for (genvar p = 0; p < N_PORT; p++) begin : g_port
      apd_port_ctl #(.CLS(PORT_CLASS[PC_W*p +: PC_W])) i_port (
         .pd     (pd),
         .oe_req (port_oe_req[p]),
         .oe     (port_oe[p]),
         .hold   (port_hold[p])
      );
   end

   AST_STBY_MATCHES_ISO: assert property (@(posedge clk_in) disable iff (rst)
      (mem_stby == '0) || (&mem_stby && bus_iso))
      else $error("standby and isolation disagree"); // R8
endmodule

// File: tb/test_apd_ctrl.sv
module test_apd_ctrl;
   localparam int AD_W = 8, N_CTL = 4, N_MEM = 3, N_PORT = 5, IDLE = 15;

   logic              clk = 1'b0;
   logic              rst, as_strobe, csi_n, cfg_we, cfg_sel;
   logic [N_CTL-1:0]  cfg_wdata;
   logic [AD_W-1:0]   mcu_ad, int_ad;
   logic [N_CTL-1:0]  mcu_ctl, logic_ctl;
   logic [N_PORT-1:0] port_oe_req, port_oe, port_hold;
   logic [N_MEM-1:0]  mem_stby;
   logic              pd_flag, bus_iso, logic_clk_en;

   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   apd_ctrl i_apd_ctrl (
      .clk_in(clk), .rst(rst), .as_strobe(as_strobe), .csi_n(csi_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .mcu_ad(mcu_ad), .mcu_ctl(mcu_ctl), .port_oe_req(port_oe_req),
      .pd_flag(pd_flag), .mem_stby(mem_stby), .bus_iso(bus_iso),
      .int_ad(int_ad), .logic_ctl(logic_ctl), .logic_clk_en(logic_clk_en),
      .port_oe(port_oe), .port_hold(port_hold)
   );

   typedef struct packed {
      logic [3:0] mask;
      logic       clkb;
      logic [4:0] oe_req;
      logic [3:0] ctl;
      logic [7:0] ad;
      logic [3:0] x_ctl;
      logic       x_clk_en;
      logic [4:0] x_oe;
      logic [4:0] x_hold;
   } vec_t;

   // Applied while in power-down; classes 0..2 hold, 3..4 float.
   localparam vec_t VEC [4] = '{
      '{4'b0000, 1'b0, 5'b11111, 4'b1111, 8'hA5, 4'b1111, 1'b1, 5'b00111, 5'b00111},
      '{4'b1010, 1'b1, 5'b10101, 4'b1111, 8'h3C, 4'b0101, 1'b0, 5'b00101, 5'b00111},
      '{4'b1111, 1'b0, 5'b01010, 4'b0110, 8'hFF, 4'b0000, 1'b1, 5'b00010, 5'b00111},
      '{4'b0001, 1'b1, 5'b11000, 4'b1011, 8'h81, 4'b1010, 1'b0, 5'b00000, 5'b00111}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic sel, input logic [3:0] data);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      tick(1);
      cfg_we = 1'b0;
   endtask

   initial begin
      #(2_000_000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; as_strobe = 1'b0; csi_n = 1'b1; cfg_we = 1'b0; cfg_sel = 1'b0;
      cfg_wdata = '0; mcu_ad = 8'h5A; mcu_ctl = 4'b1111; port_oe_req = 5'b11111;
      tick(3);
      check("R1 pd in reset", pd_flag, 0);
      rst = 1'b0;
      tick(1);
      check("R1 pd after reset", pd_flag, 0);
      check("R1 stby after reset", mem_stby, 0);
      check("R1 iso after reset", bus_iso, 0);

      // Normal operation with blocking configured but unit disabled.
      wr(1'b1, 4'b1111);
      wr(1'b0, 4'b0010);
      check("R10 normal ctl pass", logic_ctl, 4'b1111);
      check("R10 normal clk en", logic_clk_en, 1);
      check("R8 normal int_ad", int_ad, 8'h5A);
      check("R9 normal oe", port_oe, 5'b11111);
      check("R9 normal hold", port_hold, 0);
      wr(1'b1, 4'b0000);

      // R2: enable, toggle strobe, entry due on the 16th edge.
      wr(1'b0, 4'b0001);
      as_strobe = 1'b1;
      tick(IDLE);
      check("R2 not yet down", pd_flag, 0);
      tick(1);
      check("R2 down on time", pd_flag, 1);
      check("R8 stby in pd", mem_stby, 3'b111);
      check("R8 iso in pd", bus_iso, 1);
      check("R8 int_ad in pd", int_ad, 0);

      // Table walk while in power-down.
      for (int i = 0; i < 4; i++) begin
         wr(1'b1, VEC[i].mask);
         wr(1'b0, {2'b00, VEC[i].clkb, 1'b1});
         port_oe_req = VEC[i].oe_req; mcu_ctl = VEC[i].ctl; mcu_ad = VEC[i].ad;
         #1;
         check("R10 table pd", pd_flag, 1);
         check("R10 table ctl", logic_ctl, VEC[i].x_ctl);
         check("R10 table clk en", logic_clk_en, VEC[i].x_clk_en);
         check("R9 table oe", port_oe, VEC[i].x_oe);
         check("R9 table hold", port_hold, VEC[i].x_hold);
         check("R8 table int_ad", int_ad, 0);
      end

      // R7: clearing enable exits; long idle stays normal.
      wr(1'b0, 4'b0000);
      tick(1);
      check("R7 exit on disable", pd_flag, 0);
      tick(40);
      check("R7 no entry disabled", pd_flag, 0);
      // R3: saturated counter re-enters right after enable.
      wr(1'b0, 4'b0001);
      tick(1);
      check("R3 immediate entry", pd_flag, 1);

      // R4: falling strobe wakes, then re-entry after full interval.
      as_strobe = 1'b0;
      tick(1);
      check("R4 strobe wake", pd_flag, 0);
      tick(IDLE - 1);
      check("R2 falling not yet", pd_flag, 0);
      tick(1);
      check("R2 falling re-entry", pd_flag, 1);

      // R5: chip-select falling edge wakes; held low re-enters; rise ignored.
      csi_n = 1'b0;
      tick(1);
      check("R5 csi wake", pd_flag, 0);
      tick(IDLE - 1);
      check("R5 held low not yet", pd_flag, 0);
      tick(1);
      check("R5 held low re-entry", pd_flag, 1);
      csi_n = 1'b1;
      tick(2);
      check("R5 rise ignored", pd_flag, 1);

      // R6: reset wakes without a clock and holds.
      rst = 1'b1;
      #1;
      check("R6 async wake", pd_flag, 0);
      check("R6 stby cleared", mem_stby, 0);
      tick(20);
      check("R6 held in reset", pd_flag, 0);
      rst = 1'b0;
      tick(30);
      check("R1 enable cleared by reset", pd_flag, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule